// File: doc/BRIEF.md
# Timer Interrupt Status Controller

This block collects the interrupt events of a two-channel timer and presents them to software through four 32-bit registers. Ten event sources (four per timer channel, a real-time-clock tick and a write-update error) arrive as single-cycle pulses. Each pulse sets a sticky raw flag at a fixed, sparse bit position. The flag is set whether or not that source is enabled.

An enable register selects which flags may drive the level interrupt output. A masked view (raw AND enable) is readable. A write-one-to-clear register acknowledges flags. The register port is a plain write strobe with address and data. Read data is combinational from the address. The interrupt output is high while any enabled flag is set.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: Event input index k (evt_i[k]) sets the raw flag at this bit position. Indices 0 to 4 map to bits 0 to 4 (channel A time-out, A capture match, A capture event, RTC, A match). Indices 5 to 8 map to bits 8 to 11 (B time-out, B capture match, B capture event, B match). Index 9 maps to bit 16 (write-update error).
- R2: A raw flag is set on the clock edge that samples its event pulse, whatever the value of its enable bit.
- R3: Enable bit 1 lets a set flag drive irq_o. Enable bit 0 keeps that flag from driving irq_o.
- R4: Reading offset 0x8 returns the raw flags ANDed with the enable bits. Offset 0x4 returns the raw flags, and offset 0x0 returns the enable bits.
- R5: A write to offset 0xC with a 1 in a bit clears that raw flag, and so its masked bit, at that clock edge.
- R6: A raw flag stays set, and keeps irq_o asserted if enabled, until software clears it. Further events on a flag that is already set change nothing.
- R7: Zero bits written to offset 0xC leave their flags unchanged. Offset 0xC always reads 0.
- R8: If an event and a clear hit the same bit on the same edge, the bit ends up set.
- R9: Bits outside the ten event positions read 0 in every register, and writes to them are ignored. Writes to offsets 0x4 and 0x8 have no effect.
- R10: After reset, all enable and raw bits are 0 and irq_o is low.
- R11: irq_o equals the OR of all masked bits. It follows the registered state with no added cycle: it is high in the cycle right after the edge that sets an enabled flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 10 | Event pulses, compact index order given in R1 |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Byte offset; bits [3:2] select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench aims at a clear and an event striking the same bit on one edge. A design that gives the clear priority would lose the event and leave irq_o low. It drives each event index alone to pin the sparse bit map; a shifted or packed map shows up as the wrong bit in the raw register. Raw flags are raised while disabled and enabled later, which catches a design that gates latching with the enable. All-ones writes to the enable, raw and masked offsets expose reserved bits that read back set, or status that software can write directly.

// File: rtl/tirq_pkg.sv
package tirq_pkg;
  localparam int DW     = 32;
  localparam int AW     = 4;
  localparam int NUM_EV = 10;

  typedef enum logic [1:0] {
    SEL_ENA = 2'd0,
    SEL_RAW = 2'd1,
    SEL_MSK = 2'd2,
    SEL_ACK = 2'd3
  } reg_sel_e;

  // compact event index -> sparse status bit position
  function automatic int ev_pos(input int k);
    if (k < 5)      return k;
    else if (k < 9) return k + 3;
    else            return 16;
  endfunction

  function automatic logic [DW-1:0] spread_events(input logic [NUM_EV-1:0] ev);
    logic [DW-1:0] v;
    v = '0;
    for (int k = 0; k < NUM_EV; k++) v[ev_pos(k)] = ev[k];
    return v;
  endfunction

  function automatic logic [DW-1:0] live_bits();
    return spread_events({NUM_EV{1'b1}});
  endfunction

  // next raw state: set has priority over clear
  function automatic logic [DW-1:0] raw_next(input logic [DW-1:0] cur,
                                              input logic [DW-1:0] set_v,
                                              input logic [DW-1:0] clr_v);
    return (cur & ~clr_v) | set_v;
  endfunction
endpackage

// File: rtl/tirq_regif.sv
module tirq_regif
  import tirq_pkg::*;
(
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] ena_q,
  input  logic [DW-1:0] raw_q,
  output logic          ena_we,
  output logic          ack_we,
  output logic [DW-1:0] ack_bits,
  output logic [DW-1:0] bus_rdata
);
  reg_sel_e sel;
  assign sel      = reg_sel_e'(bus_addr[3:2]);
  assign ena_we   = bus_wr && (sel == SEL_ENA);
  assign ack_we   = bus_wr && (sel == SEL_ACK);
  assign ack_bits = ack_we ? (bus_wdata & live_bits()) : '0;

  always_comb begin
    unique case (sel)
      SEL_ENA: bus_rdata = ena_q;
      SEL_RAW: bus_rdata = raw_q;
      SEL_MSK: bus_rdata = raw_q & ena_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tirq_ena_reg.sv
module tirq_ena_reg
  import tirq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ena_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ena_q <= '0;
    else if (we) ena_q <= wdata & live_bits();
  end
endmodule

// File: rtl/tirq_raw_bank.sv
module tirq_raw_bank
  import tirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] evt_i,
  input  logic [DW-1:0]     ack_bits,
  output logic [DW-1:0]     ev_sparse,
  output logic [DW-1:0]     raw_q
);
  assign ev_sparse = spread_events(evt_i);

  for (genvar b = 0; b < DW; b++) begin : g_bit
    if (live_bits()[b]) begin : g_live
      logic flag_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= raw_next({{(DW-1){1'b0}}, flag_q},
                                       {{(DW-1){1'b0}}, ev_sparse[b]},
                                       {{(DW-1){1'b0}}, ack_bits[b]})[0];
      end
      assign raw_q[b] = flag_q;
    end else begin : g_rsvd
      assign raw_q[b] = 1'b0;
    end
  end
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
  import tirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] evt_i,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq_o
);
  logic [DW-1:0] ena_q, raw_q, ev_sparse, ack_bits;
  logic          ena_we, ack_we;

  tirq_regif i_regif (
    .bus_wr, .bus_addr, .bus_wdata, .ena_q, .raw_q,
    .ena_we, .ack_we, .ack_bits, .bus_rdata
  );

  tirq_ena_reg i_ena (
    .clk, .rst_n, .we(ena_we), .wdata(bus_wdata), .ena_q
  );

  tirq_raw_bank i_raw (
    .clk, .rst_n, .evt_i, .ack_bits, .ev_sparse, .raw_q
  );

  assign irq_o = |(raw_q & ena_q);
endmodule

// File: rtl/tirq_checker.sv
module tirq_checker
  import tirq_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] ev_sparse,
  input logic [DW-1:0] raw_q,
  input logic [DW-1:0] ena_q,
  input logic [DW-1:0] ack_bits,
  input logic          ena_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_rdata,
  input logic          irq_o
);
  assert_event_latches_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sparse != '0) |=> ((raw_q & $past(ev_sparse)) == $past(ev_sparse)));

  assert_clear_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_bits != '0) |=> ((raw_q & $past(ack_bits) & ~$past(ev_sparse)) == '0));

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_bits == '0) |=> (($past(raw_q) & ~raw_q) == '0));

  assert_irq_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> ((raw_q & ena_q) == '0));

  assert_irq_needs_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (ena_q != '0) && (raw_q != '0));

  assert_enable_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ena_we |=> $stable(ena_q));

  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~live_bits()) == '0);

  assert_ack_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[3:2] == 2'd3) |-> (bus_rdata == '0));
endmodule

bind tmr_irq_ctrl tirq_checker i_chk (
  .clk, .rst_n, .ev_sparse, .raw_q, .ena_q, .ack_bits, .ena_we,
  .bus_addr, .bus_rdata, .irq_o
);

// File: tb/test_tmr_irq_ctrl.sv
module test_tmr_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  evt_i = '0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] m_raw = '0;
  logic [31:0] m_ena = '0;

  always #10 clk = ~clk;

  tmr_irq_ctrl i_tmr_irq_ctrl (
    .clk, .rst_n, .evt_i, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata, .irq_o
  );

  function automatic int pos_of(input int k);
    case (k)
      0: return 0;  1: return 1;  2: return 2;  3: return 3;  4: return 4;
      5: return 8;  6: return 9;  7: return 10; 8: return 11;
      default: return 16;
    endcase
  endfunction

  function automatic logic [31:0] to_bits(input logic [9:0] ev);
    logic [31:0] r = '0;
    for (int k = 0; k < 10; k++) if (ev[k]) r = r | (32'h1 << pos_of(k));
    return r;
  endfunction

  localparam logic [31:0] LIVE = 32'h0001_0F1F;

  function automatic logic [31:0] exp_read(input logic [3:0] a);
    case (a[3:2])
      2'd0: return m_ena;
      2'd1: return m_raw;
      2'd2: return m_raw & m_ena;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, update model after edge
  task automatic step(input logic [9:0] ev, input logic wr, input logic [3:0] a,
                      input logic [31:0] d);
    @(negedge clk);
    evt_i = ev; bus_wr = wr; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    if (wr && a[3:2] == 2'd0) m_ena = d & LIVE;
    m_raw = (m_raw & ~((wr && a[3:2] == 2'd3) ? (d & LIVE) : 32'h0)) | to_bits(ev);
  endtask

  task automatic look(input string tag, input logic [3:0] a);
    @(negedge clk);
    evt_i = '0; bus_wr = 1'b0; bus_addr = a;
    #1;
    check(tag, bus_rdata, exp_read(a));
    check({tag, " irq R11"}, {31'h0, irq_o}, {31'h0, |(m_raw & m_ena)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    check("R10 irq at reset", {31'h0, irq_o}, 32'h0);
    rst_n = 1'b1;
    look("R10 enable after reset", 4'h0);
    look("R10 raw after reset", 4'h4);

    // R1 bit map, one event at a time, with R2 latching while disabled
    for (int k = 0; k < 10; k++) begin
      step(10'h1 << k, 1'b0, 4'h0, 32'h0);
      look($sformatf("R1 R2 map index %0d raw", k), 4'h4);
      check("R3 disabled irq low", {31'h0, irq_o}, 32'h0);
      step('0, 1'b1, 4'hC, 32'hFFFF_FFFF);
    end

    // R2 then R3: latched while masked, irq once enabled
    step(10'h020, 1'b0, 4'h0, 32'h0);
    look("R2 raw latched masked", 4'h4);
    step('0, 1'b1, 4'h0, 32'h0000_0100);
    look("R3 enable read", 4'h0);
    check("R3 irq after enable", {31'h0, irq_o}, 32'h1);
    look("R4 masked view", 4'h8);

    // R6 sticky over idle cycles and repeat events
    repeat (5) step('0, 1'b0, 4'h0, 32'h0);
    step(10'h020, 1'b0, 4'h0, 32'h0);
    look("R6 still set", 4'h4);

    // R7 zero write clears nothing, clear reads zero
    step('0, 1'b1, 4'hC, 32'h0);
    look("R7 raw after zero clear", 4'h4);
    look("R7 clear reads zero", 4'hC);

    // R8 event and clear on the same edge
    step(10'h020, 1'b1, 4'hC, 32'h0000_0100);
    look("R8 set wins over clear", 4'h4);
    check("R8 irq stays", {31'h0, irq_o}, 32'h1);

    // R5 clear drops raw and masked
    step('0, 1'b1, 4'hC, 32'h0000_0100);
    look("R5 raw cleared", 4'h4);
    look("R5 masked cleared", 4'h8);

    // R9 reserved bits and read-only offsets
    step('0, 1'b1, 4'h0, 32'hFFFF_FFFF);
    look("R9 enable reserved zero", 4'h0);
    step('0, 1'b1, 4'h4, 32'hFFFF_FFFF);
    look("R9 raw not writable", 4'h4);
    step('0, 1'b1, 4'h8, 32'hFFFF_FFFF);
    look("R9 masked not writable", 4'h8);

    // R11 irq one cycle after enabled event
    step(10'h200, 1'b0, 4'h0, 32'h0);
    check("R11 irq after WUE", {31'h0, irq_o}, 32'h1);
    step('0, 1'b1, 4'hC, 32'hFFFF_FFFF);

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [9:0]  ev;
      logic [3:0]  a;
      logic [31:0] d;
      logic        wr;
      ev = ($urandom % 4 == 0) ? 10'($urandom) : 10'h0;
      wr = ($urandom % 2) == 1;
      a  = {2'($urandom), 2'b00};
      d  = $urandom;
      step(ev, wr, a, d);
      look("R4 random read", {2'($urandom), 2'b00});
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule